// File: doc/BRIEF.md
# Parallel Converter Capture Receiver

This block receives the parallel output of a high-speed sampling converter on the host side. On every sample clock edge it registers the signed data bus and the out-of-range bit. One edge later it presents the sample in offset-binary form, with a valid strobe. The converter delivers twos-complement codes, and downstream filters and histograms expect unsigned codes. The receiver therefore flips only the sign bit, which maps the most negative code to zero and the most positive code to all ones.

The converter pipeline holds stale samples after its clock has stopped. A run-enable input from the clock controller tells the receiver when the clock is live. A low level on it, or a reset, marks a restart. The receiver then withholds the valid strobe until the pipeline has flushed. While the strobe is low, the data and flag outputs are forced to zero.

When the out-of-range bit is set, the converter pins its data at the positive or the negative full-scale code. The receiver decodes that code into a direction flag. Two saturating counters record the positive and negative events. Each counter has its own clear pulse from the host, and each counter steps on the same edge as the flag it counts.

Top module: `adc_capture_rx`

## Requirements
- R1: For a valid sample, out_data equals the input code with only its top bit inverted (twos complement to offset binary). For example, input 0x200 gives 0x000, 0x1FF gives 0x3FF and 0x000 gives 0x200.
- R2: A word that is stable on din before clock edge E appears on the outputs after edge E+1.
- R3: After reset, or after any edge at which run_en is sampled low, the first FLUSH_EDGES-1 (default 3) edges that sample run_en high capture invalid words. The FLUSH_EDGES-th (default fourth) such edge captures a valid word.
- R4: While out_valid is 0, out_data, out_ovr, out_ovr_pos and out_ovr_neg are all 0.
- R5: For a valid sample, out_ovr repeats the registered out-of-range bit. out_ovr_pos is 1 only when that bit is set and the code is 0x1FF. out_ovr_neg is 1 only when that bit is set and the code is 0x200. A set bit with any other code raises neither direction flag.
- R6: pos_count (neg_count) rises by one on the same edge on which out_ovr_pos (out_ovr_neg) rises for a sample. Invalid samples are never counted.
- R7: A counter at its all-ones maximum stays there and does not wrap.
- R8: A clr_pos (clr_neg) pulse sampled at an edge zeroes only its own counter at that edge. The clear takes precedence over an increment on the same edge.
- R9: While rst_n is low, out_valid, out_data, the flags and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; also counts as a restart |
| run_en | input | 1 | High while the converter clock is running; low marks a stop |
| din | input | DATA_W | Twos-complement data bus from the converter |
| ovr_in | input | 1 | Out-of-range bit from the converter |
| clr_pos | input | 1 | Clear pulse for the positive out-of-range counter |
| clr_neg | input | 1 | Clear pulse for the negative out-of-range counter |
| out_valid | output | 1 | Sample on the outputs is valid |
| out_data | output | DATA_W | Offset-binary sample, zero when not valid |
| out_ovr | output | 1 | Registered out-of-range bit, zero when not valid |
| out_ovr_pos | output | 1 | Sample pinned at positive full scale with out-of-range set |
| out_ovr_neg | output | 1 | Sample pinned at negative full scale with out-of-range set |
| pos_count | output | CNT_W | Saturating count of positive out-of-range samples |
| neg_count | output | CNT_W | Saturating count of negative out-of-range samples |

## Verification
The bench builds the receiver with DATA_W=10 and FLUSH_EDGES=4, the values the converter interface fixes. It sets CNT_W=4, so a counter reaches its ceiling after fifteen pinned samples. This lets the bench show the no-wrap rule and the clear-over-increment rule within a short run. The vector table covers two restarts: a run_en drop between bursts, and a reset taken while run_en stays high. In each case the fourth edge is the first that yields a valid word. The table also checks that a pinned code captured while blanked leaves both counters unchanged.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

  typedef enum logic [1:0] {
    OVR_NONE  = 2'd0,
    OVR_HIGH  = 2'd1,
    OVR_LOW   = 2'd2,
    OVR_OTHER = 2'd3
  } ovr_dir_e;

  // Direction of an overrange from the flag and the pinned-code matches.
  function automatic ovr_dir_e classify_ovr(input logic flag,
                                            input logic at_top,
                                            input logic at_bottom);
    if (!flag)          return OVR_NONE;
    else if (at_top)    return OVR_HIGH;
    else if (at_bottom) return OVR_LOW;
    else                return OVR_OTHER;
  endfunction

endpackage

// File: rtl/adc_rx_flush.sv
module adc_rx_flush #(
  parameter int FLUSH_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic sample_good
);
  localparam int CW = $clog2(FLUSH_EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(FLUSH_EDGES - 1);

  logic [CW-1:0] live_edges;

  // Number of consecutive earlier edges that sampled run_en high.
  always_ff @(posedge clk) begin
    if (!rst_n)               live_edges <= '0;
    else if (!run_en)         live_edges <= '0;
    else if (live_edges < LAST) live_edges <= live_edges + 1'b1;
  end

  assign sample_good = run_en && (live_edges >= LAST);
endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              ovr_in,
  input  logic              good_in,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_ovr,
  output logic              cap_good
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_data <= '0;
      cap_ovr  <= 1'b0;
      cap_good <= 1'b0;
    end else begin
      cap_data <= din;
      cap_ovr  <= ovr_in;
      cap_good <= good_in;
    end
  end
endmodule

// File: rtl/adc_rx_satcnt.sv
module adc_rx_satcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CEIL = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (clr)                  count <= '0;
    else if (hit && count != CEIL) count <= count + 1'b1;
  end
endmodule

// File: rtl/adc_capture_rx.sv
module adc_capture_rx #(
  parameter int DATA_W      = 10,
  parameter int CNT_W       = 16,
  parameter int FLUSH_EDGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [DATA_W-1:0] din,
  input  logic              ovr_in,
  input  logic              clr_pos,
  input  logic              clr_neg,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ovr,
  output logic              out_ovr_pos,
  output logic              out_ovr_neg,
  output logic [CNT_W-1:0]  pos_count,
  output logic [CNT_W-1:0]  neg_count
);
  import adc_rx_pkg::*;

  localparam logic [DATA_W-1:0] SIGN_BIT = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] TOP_CODE = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] BOT_CODE = SIGN_BIT;
  localparam int NDIR = 2;

  function automatic logic [DATA_W-1:0] to_offset_bin(input logic [DATA_W-1:0] c);
    return c ^ SIGN_BIT;
  endfunction

  logic              good_now;
  logic [DATA_W-1:0] cap_data;
  logic              cap_ovr;
  logic              cap_good;
  ovr_dir_e          cap_dir;
  logic              pos_hit;
  logic              neg_hit;

  adc_rx_flush #(.FLUSH_EDGES(FLUSH_EDGES)) u_flush (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .sample_good(good_now)
  );

  adc_rx_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .din(din), .ovr_in(ovr_in), .good_in(good_now),
    .cap_data(cap_data), .cap_ovr(cap_ovr), .cap_good(cap_good)
  );

  assign cap_dir = classify_ovr(cap_ovr, cap_data == TOP_CODE, cap_data == BOT_CODE);
  assign pos_hit = cap_good && (cap_dir == OVR_HIGH);
  assign neg_hit = cap_good && (cap_dir == OVR_LOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_ovr     <= 1'b0;
      out_ovr_pos <= 1'b0;
      out_ovr_neg <= 1'b0;
    end else begin
      out_valid   <= cap_good;
      out_data    <= cap_good ? to_offset_bin(cap_data) : '0;
      out_ovr     <= cap_good && cap_ovr;
      out_ovr_pos <= pos_hit;
      out_ovr_neg <= neg_hit;
    end
  end

  logic             hit_vec [NDIR];
  logic             clr_vec [NDIR];
  logic [CNT_W-1:0] cnt_vec [NDIR];

  assign hit_vec[0] = pos_hit;
  assign hit_vec[1] = neg_hit;
  assign clr_vec[0] = clr_pos;
  assign clr_vec[1] = clr_neg;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    adc_rx_satcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr_vec[g]), .hit(hit_vec[g]), .count(cnt_vec[g])
    );
  end

  assign pos_count = cnt_vec[0];
  assign neg_count = cnt_vec[1];
endmodule

module adc_capture_rx_chk #(
  parameter int DATA_W = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic [DATA_W-1:0] din,
  input logic              clr_pos,
  input logic              clr_neg,
  input logic              pos_hit,
  input logic              neg_hit,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ovr,
  input logic              out_ovr_pos,
  input logic              out_ovr_neg,
  input logic [CNT_W-1:0]  pos_count,
  input logic [CNT_W-1:0]  neg_count
);
  localparam logic [DATA_W-1:0] FLIP = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  CEIL = '1;

  assert_offset_bin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == ($past(din, 2) ^ FLIP));

  assert_stop_blanks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> ##1 !out_valid);

  assert_blank_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && !out_ovr && !out_ovr_pos && !out_ovr_neg));

  assert_dir_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovr_pos && out_ovr_neg));

  assert_dir_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ovr_pos || out_ovr_neg) |-> out_ovr);

  assert_pos_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_hit && !clr_pos && pos_count != CEIL) |=> pos_count == $past(pos_count) + 1'b1);

  assert_neg_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_hit && !clr_neg && neg_count != CEIL) |=> neg_count == $past(neg_count) + 1'b1);

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_count == CEIL && !clr_pos) |=> pos_count == CEIL);

  assert_clear_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pos |=> pos_count == '0);

  assert_clear_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_neg |=> neg_count == '0);
endmodule

bind adc_capture_rx adc_capture_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .din(din),
  .clr_pos(clr_pos), .clr_neg(clr_neg), .pos_hit(pos_hit), .neg_hit(neg_hit),
  .out_valid(out_valid), .out_data(out_data), .out_ovr(out_ovr),
  .out_ovr_pos(out_ovr_pos), .out_ovr_neg(out_ovr_neg),
  .pos_count(pos_count), .neg_count(neg_count)
);

// File: tb/tb_adc_capture_rx.sv
`timescale 1ns/1ps
module tb_adc_capture_rx;
  localparam int DW = 10;
  localparam int CW = 4;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b1;
  logic [DW-1:0] din = '0;
  logic ovr_in = 1'b0;
  logic clr_pos = 1'b0;
  logic clr_neg = 1'b0;
  logic out_valid, out_ovr, out_ovr_pos, out_ovr_neg;
  logic [DW-1:0] out_data;
  logic [CW-1:0] pos_count, neg_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_capture_rx #(.DATA_W(DW), .CNT_W(CW), .FLUSH_EDGES(4)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .din(din), .ovr_in(ovr_in),
    .clr_pos(clr_pos), .clr_neg(clr_neg), .out_valid(out_valid), .out_data(out_data),
    .out_ovr(out_ovr), .out_ovr_pos(out_ovr_pos), .out_ovr_neg(out_ovr_neg),
    .pos_count(pos_count), .neg_count(neg_count)
  );

  // Row: run, ovr, din, exp valid, exp ovr, exp pos, exp neg, exp data
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 10'h155, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b1, 10'h1FF, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 10'h3FF, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 10'h200, 1'b1, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 10'h1FF, 1'b1, 1'b0, 1'b0, 1'b0, 10'h3FF},
    {1'b1, 1'b1, 10'h1FF, 1'b1, 1'b1, 1'b1, 1'b0, 10'h3FF},
    {1'b1, 1'b1, 10'h200, 1'b1, 1'b1, 1'b0, 1'b1, 10'h000},
    {1'b1, 1'b0, 10'h000, 1'b1, 1'b0, 1'b0, 1'b0, 10'h200},
    {1'b0, 1'b0, 10'h123, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 10'h045, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 10'h046, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b0, 10'h047, 1'b0, 1'b0, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b1, 10'h1FF, 1'b1, 1'b1, 1'b1, 1'b0, 10'h3FF},
    {1'b1, 1'b0, 10'h100, 1'b1, 1'b0, 1'b0, 1'b0, 10'h300},
    {1'b1, 1'b1, 10'h0AA, 1'b1, 1'b1, 1'b0, 1'b0, 10'h2AA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_row(input logic [25:0] r);
    chk("R3 valid strobe", 32'(out_valid), 32'(r[13]));
    chk("R1 R4 data",      32'(out_data),  32'(r[9:0]));
    chk("R5 ovr",          32'(out_ovr),   32'(r[12]));
    chk("R5 pos flag",     32'(out_ovr_pos), 32'(r[11]));
    chk("R5 neg flag",     32'(out_ovr_neg), 32'(r[10]));
  endtask

  task automatic drive(input logic r, input logic o, input logic [DW-1:0] d);
    @(negedge clk);
    run_en = r; ovr_in = o; din = d;
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R9 valid", 32'(out_valid), 0);
    chk("R9 data", 32'(out_data), 0);
    chk("R9 pos_count", 32'(pos_count), 0);
    chk("R9 neg_count", 32'(neg_count), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table; R2: row i is seen after the edge following its capture
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25], VEC[i][24], VEC[i][23:14]);
      @(posedge clk); #1;
      if (i > 0) check_row(VEC[i-1]);
    end
    drive(1'b1, 1'b0, 10'h000);
    @(posedge clk); #1;
    check_row(VEC[NV-1]);

    // R6: counts, blanked pinned sample not counted
    chk("R6 pos_count", 32'(pos_count), 2);
    chk("R6 neg_count", 32'(neg_count), 1);

    // R8: clear positive only
    @(negedge clk); clr_pos = 1'b1;
    @(posedge clk); #1;
    chk("R8 pos cleared", 32'(pos_count), 0);
    chk("R8 neg kept", 32'(neg_count), 1);
    @(negedge clk); clr_pos = 1'b0;

    // R7: saturate at 15 with CNT_W=4
    for (int k = 0; k < 20; k++) begin
      drive(1'b1, 1'b1, 10'h1FF);
      @(posedge clk);
    end
    #1;
    chk("R7 saturated", 32'(pos_count), 15);
    chk("R7 neg untouched", 32'(neg_count), 1);

    // R8: clear wins over a same-edge increment
    @(negedge clk); clr_pos = 1'b1;
    @(posedge clk); #1;
    chk("R8 clear over hit", 32'(pos_count), 0);
    @(negedge clk); clr_pos = 1'b0;
    @(posedge clk); #1;
    chk("R6 step after clear", 32'(pos_count), 1);

    // R3: reset with run_en high is a restart; fourth edge valid
    drive(1'b1, 1'b0, 10'h001);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      chk("R3 restart after reset", 32'(out_valid), (k == 4) ? 1 : 0);
    end
    chk("R1 data after restart", 32'(out_data), 32'h201);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule